// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block holds the configuration space of a legacy Super I/O device and presents it to the host through a two-address index/data window on a plain byte-wide I/O bus. The window stays closed until the host writes the entry key 0xA5 to the index address twice in a row. A single 0xAA written to the index address closes it again. While the window is open, a write to the index address picks a register, and reads and writes at the data address reach that register.

Register 0x07 picks the active logical device. Registers from 0x30 upward form one bank for each logical device. A bank holds an activate flag, a 16-bit I/O base and an IRQ number. The block exports the enable, committed base and IRQ of every implemented logical device to the rest of the chip. The exported base is taken from the programmed value only when the device is switched from inactive to active. Firmware may rewrite the base bytes one at a time without the export ever showing a half-written address.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is closed (`cfg_unlocked`=0), every `dev_enable` bit is 0, every exported base is 0x0000, and a data-address read returns 0xFF.
- R2: The window opens only after two consecutive index-address writes of 0xA5. When one key has been seen, any other index-address write returns the block to the closed state.
- R3: An index-address write of 0xAA while open closes the window. Afterwards, data-address reads return 0xFF.
- R4: With `strap_alt`=0 the index/data addresses are 0x004E/0x004F. With `strap_alt`=1 they are 0x002E/0x002F. Accesses to any other address have no effect and read 0xFF.
- R5: While closed, data-address writes are ignored and index-address writes only advance the key sequence. While open, an index write latches the register number and data accesses reach that register.
- R6: Register 0x07 holds the selected logical device number and reads back as written. In a bank, 0x30 bit 0 is activate, 0x60 is the base high byte, 0x61 is the base low byte, and 0x70 bits 3:0 are the IRQ. Bits of 0x30 and 0x70 that are not implemented read as 0.
- R7: The implemented logical device numbers are 0x2, 0x3, 0x4, 0x5, 0x7, 0xB, 0xC, 0xD and 0xE, in export slots 0 to 8 in that order. `dev_base` slot i is bits [16i+15:16i] and `dev_irq` slot i is bits [4i+3:4i]. When any other number is selected, banked registers read 0x00 and ignore writes.
- R8: Bases of the UART devices (0x2, 0x3, 0xB, 0xC) have the low 3 bits forced to 0. The mailbox device (0xE) base has bit 0 forced to 0. The other devices keep all 16 bits.
- R9: The exported base loads the programmed base only on a write that sets activate from 0 to 1. Base writes while active read back at once but leave the export unchanged. Clearing activate drops the enable and holds the export.
- R10: Global registers 0x00 to 0x2F other than 0x07 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Selects the alternate index/data address pair |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_rd | input | 1 | Read strobe; `io_rdata` is valid in the same cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| cfg_unlocked | output | 1 | Configuration window open |
| dev_enable | output | 9 | Activate flag per export slot |
| dev_base | output | 144 | Committed I/O base, 16 bits per slot |
| dev_irq | output | 36 | IRQ number, 4 bits per slot |

## Verification
The hardest case to reach is a base that has been rewritten while its device stays active, because the export must keep the old value while readback shows the new one. The stimulus programs a UART base, activates it, and rewrites the low byte while it is still active. It then compares the register readback against the unchanged export, deactivates and reactivates the device, and checks that the new base arrives only at that point. The broken key sequence (0xA5, another value, 0xA5) and a key written to the wrong address pair after the strap changes are also driven on purpose.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int NUM_LDN = 9;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int BASE_W  = 16;
    localparam int IRQ_W   = 4;

    localparam logic [ADDR_W-1:0] PAIR_PRI = 16'h004E;
    localparam logic [ADDR_W-1:0] PAIR_ALT = 16'h002E;

    localparam logic [DATA_W-1:0] KEY_ENTER   = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_LEAVE   = 8'hAA;
    localparam logic [DATA_W-1:0] REG_LDN     = 8'h07;
    localparam logic [DATA_W-1:0] GLOBAL_LAST = 8'h2F;
    localparam logic [DATA_W-1:0] REG_ACT     = 8'h30;
    localparam logic [DATA_W-1:0] REG_BASE_HI = 8'h60;
    localparam logic [DATA_W-1:0] REG_BASE_LO = 8'h61;
    localparam logic [DATA_W-1:0] REG_IRQ     = 8'h70;
    localparam logic [DATA_W-1:0] IDLE_READ   = 8'hFF;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    // Decoded host access for one cycle
    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } port_hit_t;

    // Logical device number held in each export slot
    function automatic logic [DATA_W-1:0] slot_ldn(input int slot);
        case (slot)
            0:       return 8'h02;
            1:       return 8'h03;
            2:       return 8'h04;
            3:       return 8'h05;
            4:       return 8'h07;
            5:       return 8'h0B;
            6:       return 8'h0C;
            7:       return 8'h0D;
            default: return 8'h0E;
        endcase
    endfunction

    // Number of low base bits forced to zero for each slot
    function automatic int slot_align(input int slot);
        case (slot)
            0, 1, 5, 6: return 3;
            8:          return 1;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
    import sio_cfg_pkg::*;
(
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output port_hit_t         hit
);
    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;
    logic              at_idx;
    logic              at_dat;

    assign idx_addr = strap_alt ? PAIR_ALT : PAIR_PRI;
    assign dat_addr = idx_addr + ADDR_W'(1);
    assign at_idx   = (io_addr == idx_addr);
    assign at_dat   = (io_addr == dat_addr);

    always_comb begin
        hit.idx_wr = at_idx & io_wr;
        hit.idx_rd = at_idx & io_rd;
        hit.dat_wr = at_dat & io_wr;
        hit.dat_rd = at_dat & io_rd;
    end
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked,
    output logic [DATA_W-1:0] cur_idx
);
    key_state_e state_q, state_d;
    logic [DATA_W-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            case (state_q)
                KEY_LOCKED: state_d = (wdata == KEY_ENTER) ? KEY_HALF : KEY_LOCKED;
                KEY_HALF:   state_d = (wdata == KEY_ENTER) ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN:   state_d = (wdata == KEY_LEAVE) ? KEY_LOCKED : KEY_OPEN;
                default:    state_d = KEY_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KEY_LOCKED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (idx_wr && state_q == KEY_OPEN && wdata != KEY_LEAVE)
                idx_q <= wdata;
        end
    end

    assign unlocked = (state_q == KEY_OPEN);
    assign cur_idx  = idx_q;

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_ENTER)); // R2

    AST_LEAVE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr && wdata == KEY_LEAVE) |=> !unlocked); // R3

    AST_INDEX_HELD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(cur_idx)); // R5
endmodule

// File: rtl/sio_ldn_bank.sv
module sio_ldn_bank
    import sio_cfg_pkg::*;
#(
    parameter int ALIGN_BITS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              active,
    output logic [BASE_W-1:0] base_out,
    output logic [IRQ_W-1:0]  irq_out
);
    localparam logic [BASE_W-1:0] ALIGN_MASK = {BASE_W{1'b1}} << ALIGN_BITS;

    logic              act_q;
    logic [BASE_W-1:0] shadow_q;
    logic [BASE_W-1:0] base_q;
    logic [IRQ_W-1:0]  irq_q;
    logic              wr_here;

    assign wr_here = sel & wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            shadow_q <= '0;
            base_q   <= '0;
            irq_q    <= '0;
        end else if (wr_here) begin
            case (idx)
                REG_ACT: begin
                    act_q <= wdata[0];
                    if (wdata[0] && !act_q)
                        base_q <= shadow_q;
                end
                REG_BASE_HI: shadow_q <= {wdata, shadow_q[7:0]} & ALIGN_MASK;
                REG_BASE_LO: shadow_q <= {shadow_q[15:8], wdata} & ALIGN_MASK;
                REG_IRQ:     irq_q    <= wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (sel) begin
            case (idx)
                REG_ACT:     rd_data = {{(DATA_W-1){1'b0}}, act_q};
                REG_BASE_HI: rd_data = shadow_q[15:8];
                REG_BASE_LO: rd_data = shadow_q[7:0];
                REG_IRQ:     rd_data = {{(DATA_W-IRQ_W){1'b0}}, irq_q};
                default:     rd_data = '0;
            endcase
        end
    end

    assign active   = act_q;
    assign base_out = base_q;
    assign irq_out  = irq_q;

    AST_EXPORT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (act_q && $past(act_q)) |-> $stable(base_q)); // R9

    AST_ACTIVATE_LOADS: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> (base_q == $past(shadow_q))); // R9
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      strap_alt,
    input  logic [ADDR_W-1:0]         io_addr,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic [DATA_W-1:0]         io_wdata,
    output logic [DATA_W-1:0]         io_rdata,
    output logic                      cfg_unlocked,
    output logic [NUM_LDN-1:0]        dev_enable,
    output logic [NUM_LDN*BASE_W-1:0] dev_base,
    output logic [NUM_LDN*IRQ_W-1:0]  dev_irq
);
    port_hit_t         hit;
    logic              unlocked;
    logic [DATA_W-1:0] cur_idx;
    logic [DATA_W-1:0] ldn_q;
    logic              cfg_wr;
    logic              bank_wr;
    logic [DATA_W-1:0] bank_rd [NUM_LDN];
    logic [DATA_W-1:0] bank_or;
    logic [DATA_W-1:0] cfg_rdata;

    sio_port_decode u_decode (
        .strap_alt (strap_alt),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .hit       (hit)
    );

    sio_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (hit.idx_wr),
        .wdata    (io_wdata),
        .unlocked (unlocked),
        .cur_idx  (cur_idx)
    );

    assign cfg_wr  = hit.dat_wr & unlocked;
    assign bank_wr = cfg_wr & (cur_idx > GLOBAL_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            ldn_q <= '0;
        else if (cfg_wr && cur_idx == REG_LDN)
            ldn_q <= io_wdata;
    end

    for (genvar s = 0; s < NUM_LDN; s++) begin : g_bank
        localparam logic [DATA_W-1:0] CODE = slot_ldn(s);
        sio_ldn_bank #(
            .ALIGN_BITS (slot_align(s))
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .sel      (ldn_q == CODE),
            .wr       (bank_wr),
            .idx      (cur_idx),
            .wdata    (io_wdata),
            .rd_data  (bank_rd[s]),
            .active   (dev_enable[s]),
            .base_out (dev_base[s*BASE_W +: BASE_W]),
            .irq_out  (dev_irq[s*IRQ_W +: IRQ_W])
        );
    end

    always_comb begin
        bank_or = '0;
        for (int s = 0; s < NUM_LDN; s++)
            bank_or = bank_or | bank_rd[s];
    end

    always_comb begin
        if (cur_idx <= GLOBAL_LAST)
            cfg_rdata = (cur_idx == REG_LDN) ? ldn_q : '0;
        else
            cfg_rdata = bank_or;
    end

    always_comb begin
        io_rdata = IDLE_READ;
        if (unlocked) begin
            if (hit.idx_rd)
                io_rdata = cur_idx;
            else if (hit.dat_rd)
                io_rdata = cfg_rdata;
        end
    end

    assign cfg_unlocked = unlocked;

    AST_LDN_HELD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(ldn_q)); // R5

    AST_ENABLES_STILL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && $past(!unlocked)) |-> $stable(dev_enable)); // R5
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
    import sio_cfg_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      strap_alt;
    logic [ADDR_W-1:0]         io_addr;
    logic                      io_wr;
    logic                      io_rd;
    logic [DATA_W-1:0]         io_wdata;
    logic [DATA_W-1:0]         io_rdata;
    logic                      cfg_unlocked;
    logic [NUM_LDN-1:0]        dev_enable;
    logic [NUM_LDN*BASE_W-1:0] dev_base;
    logic [NUM_LDN*IRQ_W-1:0]  dev_irq;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic [ADDR_W-1:0] ip;
    logic [ADDR_W-1:0] dp;

    always #5 clk = ~clk;

    sio_cfg_port u_dut (
        .clk(clk), .rst(rst), .strap_alt(strap_alt), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_unlocked(cfg_unlocked), .dev_enable(dev_enable),
        .dev_base(dev_base), .dev_irq(dev_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: reads carry no side effect, so sample just after the edge
    always @(posedge clk) begin
        #1;
        if (io_rd && exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({24'h0, io_rdata}, {24'h0, e}, t);
        end
    end

    task automatic wr_port(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_port(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr_port(ip, idx);
        wr_port(dp, d);
    endtask

    task automatic cfg_rd(input logic [7:0] idx, input logic [7:0] e, input string tag);
        wr_port(ip, idx);
        rd_port(dp, e, tag);
    endtask

    function automatic logic [15:0] base_of(input int slot);
        return dev_base[slot*16 +: 16];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; strap_alt = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
        ip = 16'h004E; dp = 16'h004F;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk({31'h0, cfg_unlocked}, 0, "R1 locked");
        chk({23'h0, dev_enable}, 0, "R1 enables");
        chk({16'h0, base_of(0)}, 0, "R1 base slot0");
        rd_port(dp, 8'hFF, "R1 data read");

        // R5 locked writes ignored
        wr_port(ip, 8'h07);
        wr_port(dp, 8'h05);
        rd_port(dp, 8'hFF, "R5 locked read");

        // R2 broken sequence
        wr_port(ip, 8'hA5); wr_port(ip, 8'h00); wr_port(ip, 8'hA5);
        chk({31'h0, cfg_unlocked}, 0, "R2 broken key");
        wr_port(ip, 8'hA5);
        chk({31'h0, cfg_unlocked}, 1, "R2 unlock");
        rd_port(dp, 8'h00, "R10 global reg 0");
        cfg_rd(8'h07, 8'h00, "R5 ldn untouched while locked");

        // R6 / R8 UART slot0 (LDN 2)
        cfg_wr(8'h07, 8'h02);
        cfg_rd(8'h07, 8'h02, "R6 ldn readback");
        rd_port(ip, 8'h07, "R5 index readback");
        cfg_wr(8'h60, 8'h03);
        cfg_wr(8'h61, 8'hFF);
        cfg_rd(8'h61, 8'hF8, "R8 uart align");
        cfg_rd(8'h60, 8'h03, "R6 base hi");
        chk({16'h0, base_of(0)}, 0, "R9 no export before activate");
        cfg_wr(8'h70, 8'h14);
        cfg_rd(8'h70, 8'h04, "R6 irq field");
        cfg_wr(8'h30, 8'h01);
        chk({31'h0, dev_enable[0]}, 1, "R6 activate");
        chk({16'h0, base_of(0)}, 32'h03F8, "R9 export on activate");
        chk({28'h0, dev_irq[3:0]}, 4, "R7 irq slot0");

        // R9 rewrite while active
        cfg_wr(8'h61, 8'h00);
        cfg_rd(8'h61, 8'h00, "R9 readback while active");
        chk({16'h0, base_of(0)}, 32'h03F8, "R9 export frozen");
        cfg_wr(8'h30, 8'h00);
        chk({31'h0, dev_enable[0]}, 0, "R9 deactivate");
        chk({16'h0, base_of(0)}, 32'h03F8, "R9 export held");
        cfg_wr(8'h30, 8'h01);
        chk({16'h0, base_of(0)}, 32'h0300, "R9 reactivate loads");

        // R8 mailbox slot8 and keyboard slot3
        cfg_wr(8'h07, 8'h0E);
        cfg_wr(8'h60, 8'h12); cfg_wr(8'h61, 8'h37); cfg_wr(8'h30, 8'h01);
        chk({16'h0, base_of(8)}, 32'h1236, "R8 mailbox align");
        cfg_wr(8'h07, 8'h05);
        cfg_wr(8'h61, 8'h67); cfg_wr(8'h30, 8'h01);
        chk({16'h0, base_of(3)}, 32'h0067, "R8 no align kbc");

        // R7 unimplemented ldn
        cfg_wr(8'h07, 8'h06);
        cfg_wr(8'h30, 8'h01);
        cfg_rd(8'h30, 8'h00, "R7 unimplemented reads zero");
        chk({23'h0, dev_enable}, 32'h109, "R7 enables unchanged");
        cfg_wr(8'h07, 8'h0D);
        cfg_wr(8'h30, 8'h01);
        chk({31'h0, dev_enable[7]}, 1, "R7 ldn 0xD slot7");

        // R10 other global
        cfg_wr(8'h20, 8'h55);
        cfg_rd(8'h20, 8'h00, "R10 global ignored");
        cfg_wr(8'h07, 8'h06);

        // R3 relock
        wr_port(ip, 8'hAA);
        chk({31'h0, cfg_unlocked}, 0, "R3 relock");
        rd_port(dp, 8'hFF, "R3 data read locked");
        rd_port(ip, 8'hFF, "R3 index read locked");

        // R4 strap pair
        strap_alt = 1'b1;
        wr_port(16'h004E, 8'hA5); wr_port(16'h004E, 8'hA5);
        chk({31'h0, cfg_unlocked}, 0, "R4 old pair ignored");
        ip = 16'h002E; dp = 16'h002F;
        wr_port(ip, 8'hA5); wr_port(ip, 8'hA5);
        chk({31'h0, cfg_unlocked}, 1, "R4 alt pair unlock");
        cfg_rd(8'h07, 8'h06, "R4 alt pair access");
        rd_port(16'h004F, 8'hFF, "R4 foreign address");

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule